// File: doc/BRIEF.md
# Half-Step Fractional Clock Divider

This block turns one of three source clock references into a slower output clock. The ratio is a pre-divide of 2, 2.5 or 3 times an integer divide of 2 to 127. It is meant for pixel-clock and audio master-clock generation.

All logic runs on a single fast system clock. Each source is presented as an enable pulse at twice that source's rate, so a half-step ratio of 2.5 becomes a whole count of 5 pulses. The output is a one-cycle enable pulse, issued once per output period.

A 16-bit control word selects the source, sets both dividers and enables the output. The word is latched into an active copy only at a period boundary, or while the divider is stopped. A retune therefore never shortens or stretches a period in progress. A combination that cannot run stops the output and raises a status flag.

Top module: `halfstep_clkdiv`

## Requirements
- R1: After reset the output pulse is low and the error flag is high, because the active configuration resets to all zeros.
- R2: The control word has these fields:
  - bits 6:0 are the integer divide value `div`;
  - bits 9:8 are the pre-divide code `pre`;
  - bit 12 chooses a PLL over the crystal;
  - bit 13 chooses PLL2 over PLL1;
  - bit 15 is the enable.

  While running, one output pulse is issued for every (pre+3)×div ticks of the selected source. With ticks at twice the source rate, codes 1, 2 and 3 give pre-divide ratios of 2, 2.5 and 3.
- R3: A pre-divide code of 0 produces no output pulses and holds the error flag high.
- R4: A divide value of 0 or 1 produces no output pulses and holds the error flag high.
- R5: With bit 15 clear in the active configuration, no pulses are produced. The error flag then reflects only the validity of the divider fields.
- R6: Source selection works as follows:
  - bit 12 clear selects source 0, whatever bit 13 holds;
  - bit 12 set with bit 13 clear selects source 1;
  - bits 12 and 13 both set select source 2.

  Ticks on unselected sources do not advance the count.
- R7: Each output pulse is exactly one cycle wide. It appears in the cycle after the clock edge that counts the last tick of a period.
- R8: A control word change made while the divider runs takes effect only at the next period boundary. This includes a change presented in the very cycle of the terminal tick, which becomes the setting for the following period.
- R9: While stopped, the divider loads the control word at every edge. A valid word presented while stopped starts a full period counted from the following cycle.
- R10: The error flag is high exactly when the active configuration has a zero pre-divide code or a divide value below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_i | input | 16 | Control word: divide, pre-divide, source select, enable |
| ref_tick_i | input | 3 | Per-source tick enables at twice each source rate |
| div_tick_o | output | 1 | One-cycle output clock enable pulse |
| cfg_err_o | output | 1 | Active configuration cannot run |

## Verification
The delicate coincidence is a control word write landing in the same cycle as the terminal tick of a period. The period ends and the shadow register reloads on one edge.

The bench counts seven ticks of an 8-tick period, then presents a new word together with the eighth tick. It requires two things:
- the pulse still follows that eighth tick, as the old setting dictates;
- the next period has the new length.

A mid-period write and a mid-period disable are checked the same way, by measuring the length of the period that was running when the write arrived.

// File: rtl/hsd_pkg.sv
`timescale 1ns/1ps
package hsd_pkg;
  localparam int CW_W     = 16;
  localparam int DIV_W    = 7;
  localparam int PRE_W    = 2;
  localparam int DIV_LSB  = 0;
  localparam int PRE_LSB  = 8;
  localparam int PLL_BIT  = 12;
  localparam int ALT_BIT  = 13;
  localparam int EN_BIT   = 15;
  localparam int PRE_BIAS = 3;   // pre-divide count = code + bias
  localparam int DIV_MIN  = 2;

  typedef struct packed {
    logic             en;
    logic [1:0]       sel;   // [0] use pll, [1] pick second pll
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic cfg_t hsd_unpack(input logic [CW_W-1:0] w);
    cfg_t c;
    c.en  = w[EN_BIT];
    c.sel = {w[ALT_BIT], w[PLL_BIT]};
    c.pre = w[PRE_LSB +: PRE_W];
    c.div = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic hsd_cfg_ok(input cfg_t c);
    return (c.pre != '0) && (c.div >= DIV_W'(DIV_MIN));
  endfunction
endpackage

// File: rtl/hsd_rst_sync.sv
`timescale 1ns/1ps
module hsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/hsd_cfg_shadow.sv
`timescale 1ns/1ps
module hsd_cfg_shadow
  import hsd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cfg_t word_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q;
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load_i) cfg_d = word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/hsd_src_pick.sv
`timescale 1ns/1ps
module hsd_src_pick #(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic [1:0]         sel_i,
  output logic               tick_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [IDX_W-1:0]   idx;
  logic [NUM_SRC-1:0] hit;

  // crystal unless pll chosen; then first or second pll
  always_comb begin
    if (!sel_i[0])      idx = IDX_W'(0);
    else if (!sel_i[1]) idx = IDX_W'(1);
    else                idx = IDX_W'(2);
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
    assign hit[g] = tick_i[g] & (idx == IDX_W'(g));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/hsd_period_ctr.sv
`timescale 1ns/1ps
module hsd_period_ctr #(
  parameter int PRE_W  = 2,
  parameter int DIV_W  = 7,
  parameter int BIAS   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             term_o
);
  localparam int PC_W = PRE_W + 1;

  logic [PC_W-1:0]  pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             pre_last, div_last, term;

  always_comb begin
    pre_last = (pre_q == ({1'b0, pre_i} + PC_W'(BIAS - 1)));
    div_last = (div_q == (div_i - DIV_W'(1)));
    term     = run_i & step_i & pre_last & div_last;
    pre_d    = pre_q;
    div_d    = div_q;
    if (!run_i || term) begin
      pre_d = '0;
      div_d = '0;
    end else if (step_i) begin
      if (pre_last) begin
        pre_d = '0;
        div_d = div_q + DIV_W'(1);
      end else begin
        pre_d = pre_q + PC_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end

  assign term_o = term;
endmodule

// File: rtl/halfstep_clkdiv.sv
`timescale 1ns/1ps
module halfstep_clkdiv
  import hsd_pkg::*;
#(
  parameter int NUM_SRC    = 3,
  parameter int RST_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CW_W-1:0]    ctrl_i,
  input  logic [NUM_SRC-1:0] ref_tick_i,
  output logic               div_tick_o,
  output logic               cfg_err_o
);
  logic rst_n_s;
  cfg_t word_dec;
  cfg_t cfg_act;
  logic cfg_ok, running, load, step, term;
  logic pulse_q, pulse_d;

  hsd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  assign word_dec = hsd_unpack(ctrl_i);

  hsd_cfg_shadow u_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .load_i(load),
    .word_i(word_dec),
    .cfg_o (cfg_act)
  );

  always_comb begin
    cfg_ok  = hsd_cfg_ok(cfg_act);
    running = cfg_act.en & cfg_ok;
    load    = !running | term;   // boundary or stopped
  end

  hsd_src_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .tick_i(ref_tick_i),
    .sel_i (cfg_act.sel),
    .tick_o(step)
  );

  hsd_period_ctr #(.PRE_W(PRE_W), .DIV_W(DIV_W), .BIAS(PRE_BIAS)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .run_i (running),
    .step_i(step),
    .pre_i (cfg_act.pre),
    .div_i (cfg_act.div),
    .term_o(term)
  );

  always_comb pulse_d = term;

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) pulse_q <= 1'b0;
    else          pulse_q <= pulse_d;
  end

  assign div_tick_o = pulse_q;
  assign cfg_err_o  = !cfg_ok;
endmodule

// File: rtl/hsd_chk.sv
`timescale 1ns/1ps
module hsd_chk #(
  parameter int NUM_SRC = 3,
  parameter int CFG_W   = 12
) (
  input logic               clk_i,
  input logic               rst_n_s,
  input logic [NUM_SRC-1:0] ref_tick_i,
  input logic [CFG_W-1:0]   cfg_act,
  input logic               running,
  input logic               term,
  input logic               div_tick_o,
  input logic               cfg_err_o
);
  // R7
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    div_tick_o |=> !div_tick_o);

  // R7
  term_to_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    term |=> div_tick_o);

  // R6
  no_tick_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (ref_tick_i == '0) |=> !div_tick_o);

  // R3, R4
  bad_cfg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    cfg_err_o |=> !div_tick_o);

  // R5
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !cfg_act[CFG_W-1] |=> !div_tick_o);

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (running && !term) |=> $stable(cfg_act));
endmodule

bind halfstep_clkdiv hsd_chk #(.NUM_SRC(NUM_SRC), .CFG_W(hsd_pkg::CFG_W)) u_hsd_chk (
  .clk_i     (clk_i),
  .rst_n_s   (rst_n_s),
  .ref_tick_i(ref_tick_i),
  .cfg_act   (cfg_act),
  .running   (running),
  .term      (term),
  .div_tick_o(div_tick_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/test_halfstep_clkdiv.sv
`timescale 1ns/1ps
module test_halfstep_clkdiv;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] ctrl_i;
  logic [2:0]  ref_tick_i;
  logic        div_tick_o;
  logic        cfg_err_o;
  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  halfstep_clkdiv i_halfstep_clkdiv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl_i),
    .ref_tick_i(ref_tick_i),
    .div_tick_o(div_tick_o),
    .cfg_err_o (cfg_err_o)
  );

  function automatic logic [15:0] mk(input bit en, input bit [1:0] sel,
                                     input int pre, input int dv);
    logic [15:0] w = '0;
    w[15]  = en;
    w[12]  = sel[0];
    w[13]  = sel[1];
    w[9:8] = 2'(pre);
    w[6:0] = 7'(dv);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; ctrl_i = '0; ref_tick_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  // drive the selected source (gapped if asked) and every other source
  // constantly; return ticks of the selected source until a pulse is seen
  task automatic count_to_pulse(input int src, input bit gap, output int n);
    n = -1;
    for (int i = 0, k = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if (div_tick_o) begin n = k; break; end
      ref_tick_i = 3'b111;
      if (gap && i[0]) ref_tick_i[src] = 1'b0;
      else k++;
    end
    ref_tick_i = '0;
  endtask

  task automatic give_ticks(input int src, input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk_i);
      ref_tick_i = '0;
      ref_tick_i[src] = 1'b1;
    end
    @(negedge clk_i);
    ref_tick_i = '0;
  endtask

  task automatic no_pulse(input int cyc, input string req);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk_i);
      if (div_tick_o) seen++;
      ref_tick_i = 3'b111;
    end
    @(negedge clk_i);
    if (div_tick_o) seen++;
    ref_tick_i = '0;
    check(seen == 0, req, seen, 0);
  endtask

  task automatic start(input logic [15:0] w);
    do_reset();
    ctrl_i = w;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    check(div_tick_o == 1'b0, "R1 pulse", div_tick_o, 0);
    check(cfg_err_o == 1'b1, "R1 err", cfg_err_o, 1);
  endtask

  task automatic t_min();
    int n;
    start(mk(1, 2'b00, 1, 2));
    check(cfg_err_o == 1'b0, "R10 err low", cfg_err_o, 0);
    count_to_pulse(0, 0, n);
    check(n == 8, "R2 R9 min period", n, 8);
    @(negedge clk_i);
    check(div_tick_o == 1'b0, "R7 width", div_tick_o, 0);
    count_to_pulse(0, 1, n);
    check(n == 8, "R2 repeat period gapped", n, 8);
  endtask

  task automatic t_sources();
    int n;
    start(mk(1, 2'b01, 2, 5));
    count_to_pulse(1, 1, n);
    check(n == 25, "R6 R2 src1 pre2.5", n, 25);
    start(mk(1, 2'b10, 2, 2));
    count_to_pulse(0, 1, n);
    check(n == 10, "R6 alt bit ignored without pll", n, 10);
    start(mk(1, 2'b11, 3, 127));
    count_to_pulse(2, 1, n);
    check(n == 762, "R2 R6 src2 max", n, 762);
  endtask

  task automatic t_invalid();
    int n;
    start(mk(1, 2'b00, 0, 5));
    check(cfg_err_o == 1'b1, "R3 err", cfg_err_o, 1);
    no_pulse(200, "R3 silent");
    ctrl_i = mk(1, 2'b00, 2, 1);
    @(negedge clk_i);
    check(cfg_err_o == 1'b1, "R4 div1 err", cfg_err_o, 1);
    no_pulse(200, "R4 div1 silent");
    ctrl_i = mk(1, 2'b00, 2, 0);
    @(negedge clk_i);
    check(cfg_err_o == 1'b1, "R4 div0 err", cfg_err_o, 1);
    no_pulse(200, "R4 div0 silent");
    ctrl_i = mk(1, 2'b00, 1, 2);
    @(negedge clk_i);
    check(cfg_err_o == 1'b0, "R10 err clears", cfg_err_o, 0);
    count_to_pulse(0, 0, n);
    check(n == 8, "R9 start from stopped", n, 8);
  endtask

  task automatic t_disabled();
    start(mk(0, 2'b00, 1, 4));
    check(cfg_err_o == 1'b0, "R5 err valid", cfg_err_o, 0);
    no_pulse(300, "R5 disabled silent");
  endtask

  task automatic t_midchange();
    int n;
    start(mk(1, 2'b00, 1, 2));
    give_ticks(0, 3);
    ctrl_i = mk(1, 2'b00, 3, 3);
    count_to_pulse(0, 0, n);
    check(n == 5, "R8 old period kept", n, 5);
    count_to_pulse(0, 0, n);
    check(n == 18, "R8 new period", n, 18);
  endtask

  task automatic t_coincide();
    int n;
    start(mk(1, 2'b00, 1, 2));
    give_ticks(0, 7);
    ctrl_i = mk(1, 2'b00, 2, 2);
    ref_tick_i = 3'b001;
    @(negedge clk_i);
    ref_tick_i = '0;
    check(div_tick_o == 1'b1, "R8 R7 terminal pulse", div_tick_o, 1);
    count_to_pulse(0, 0, n);
    check(n == 10, "R8 write at boundary", n, 10);
  endtask

  task automatic t_disable_run();
    int n;
    start(mk(1, 2'b01, 1, 3));
    give_ticks(1, 4);
    ctrl_i = mk(0, 2'b01, 1, 3);
    count_to_pulse(1, 0, n);
    check(n == 8, "R8 disable waits", n, 8);
    no_pulse(100, "R5 off after boundary");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #400us;
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    t_reset();
    t_min();
    t_sources();
    t_invalid();
    t_disabled();
    t_midchange();
    t_coincide();
    t_disable_run();
    finish_run();
  end
endmodule